// File: doc/BRIEF.md
# Selectable Periodic Waveform Generator

This block produces a stream of 8-bit unsigned samples, one per clock, for a pulse-width modulator that follows it and turns each sample into an analogue level. A 3-bit shape code selects the waveform: square, rising ramp, triangle, or a sine value that another unit computes and presents on an input port. All shapes are taken from one shared 256-step phase counter.

A 2-bit rate code sets how often that phase counter steps, which gives four output frequencies. A 2-bit gain code attenuates the chosen sample by shifting it right. The sample output is registered. Changing the shape, rate or gain never restarts the phase. A synchronous, active-high reset returns the phase, the prescale count and the output to zero.

Top module: `wfgen_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge clears the phase counter, the prescale count and `sample_out` to 0. `sample_out` reads 0 after the edge.
- R2: `sample_out` is registered. After each edge it holds the value computed from the phase before that edge and from the inputs before that edge. A change of `shape_sel` shows on the next edge and does not reset the phase.
- R3: Shape code 0 (square) yields 255 while the phase is below 128, and 0 from 128 to 255.
- R4: Shape code 1 (ramp) yields the phase value itself.
- R5: Shape code 2 (triangle) yields phase×2 while the phase is below 128, and 255−(phase−128)×2 otherwise.
- R6: Shape code 3 passes the value of `sine_in` from before the edge to the output.
- R7: Shape codes 4, 5, 6 and 7 drive the output to 0.
- R8: A free-running 3-bit prescale count starts at 0 after reset and advances by one on every clock. The phase steps by one on each clock at which the low `rate_sel` bits of that count are all ones. Rate codes 0, 1, 2 and 3 therefore step the phase every 1st, 2nd, 4th or 8th clock, for periods of 256, 512, 1024 and 2048 clocks.
- R9: Gain codes 0, 1, 2 and 3 shift the selected sample right by 0, 1, 2 or 3 bits and fill with zeros.
- R10: At rate code 0 the phase advances on every clock and wraps from 255 to 0, so every shape repeats every 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shape_sel | input | 3 | Waveform code: 0 square, 1 ramp, 2 triangle, 3 sine, 4 to 7 zero |
| rate_sel | input | 2 | Phase step interval code: every 1, 2, 4 or 8 clocks |
| gain_sel | input | 2 | Right-shift amount applied to the sample |
| sine_in | input | 8 | Externally computed sine sample, offset into the unsigned range |
| sample_out | output | 8 | Registered unsigned output sample |

## Verification
The bench builds the block with its default parameters: an 8-bit phase and sample, and a 2-bit rate code. With these values a full period even at the slowest rate, 2048 clocks, fits many times into the run. Every rate and gain code can be reached, as can both phase halves and the 255-to-0 wrap. A cycle-by-cycle predictor replays the prescale and phase arithmetic from the requirements. This exposes any wrong step interval or wrong wrap point, as well as a phase that restarts when the shape changes or after a reset in the middle of a run.

// File: rtl/wfgen_pkg.sv
package wfgen_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SHP_SQUARE = 3'd0,
        SHP_RAMP   = 3'd1,
        SHP_TRI    = 3'd2,
        SHP_SINE   = 3'd3
    } shape_e;

endpackage

// File: rtl/wfgen_phase_timer.sv
module wfgen_phase_timer #(
    parameter int PH_W   = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [PH_W-1:0]   phase
);

    localparam int PRE_W = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [PRE_W-1:0] pre;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [PRE_W-1:0] mask_d;
    logic             step_d;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask_d[i] = (i < int'(rate_sel));
        end
        step_d       = ((tmr_q.pre & mask_d) == mask_d);
        tmr_d        = tmr_q;
        tmr_d.pre    = tmr_q.pre + 1'b1;
        if (step_d) begin
            tmr_d.phase = tmr_q.phase + 1'b1;
        end
        if (rst) begin
            tmr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign phase = tmr_q.phase;

    // R1: reset clears the phase and the prescale count
    assert_timer_reset_R1: assert property (@(posedge clk)
        rst |=> (tmr_q == '0));

    // R8: the phase either holds or moves up by exactly one
    assert_phase_single_step_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((tmr_q.phase == $past(tmr_q.phase)) ||
                  (tmr_q.phase == PH_W'($past(tmr_q.phase) + 1'b1))));

    // R10: at the base rate the phase moves on every clock
    assert_base_rate_step_R10: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0) |=> (tmr_q.phase == PH_W'($past(tmr_q.phase) + 1'b1)));

endmodule

// File: rtl/wfgen_shape_mapper.sv
module wfgen_shape_mapper
    import wfgen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     phase,
    input  logic [SEL_W-1:0] shape_sel,
    input  logic [W-1:0]     sine_in,
    output logic [W-1:0]     shape_val
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic          upper_half;
    logic [W-1:0]  doubled;

    always_comb begin
        upper_half = phase[W-1];
        doubled    = {phase[W-2:0], 1'b0};
        case (shape_sel)
            SHP_SQUARE: shape_val = upper_half ? '0 : MAXV;
            SHP_RAMP:   shape_val = phase;
            SHP_TRI:    shape_val = upper_half ? ~doubled : doubled;
            SHP_SINE:   shape_val = sine_in;
            default:    shape_val = '0;
        endcase
    end

endmodule

// File: rtl/wfgen_gain_shifter.sv
module wfgen_gain_shifter #(
    parameter int W      = 8,
    parameter int GAIN_W = 2
) (
    input  logic [W-1:0]      raw,
    input  logic [GAIN_W-1:0] gain_sel,
    output logic [W-1:0]      scaled
);

    always_comb begin
        scaled = raw >> gain_sel;
    end

endmodule

// File: rtl/wfgen_core.sv
module wfgen_core
    import wfgen_pkg::*;
#(
    parameter int W      = 8,
    parameter int RATE_W = 2,
    parameter int GAIN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  shape_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [GAIN_W-1:0] gain_sel,
    input  logic [W-1:0]      sine_in,
    output logic [W-1:0]      sample_out
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] sample;
    } out_t;

    logic [W-1:0] phase;
    logic [W-1:0] shape_val;
    logic [W-1:0] scaled;
    out_t         out_d, out_q;

    wfgen_phase_timer #(.PH_W(W), .RATE_W(RATE_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .phase    (phase)
    );

    wfgen_shape_mapper #(.W(W)) mapper_i (
        .phase     (phase),
        .shape_sel (shape_sel),
        .sine_in   (sine_in),
        .shape_val (shape_val)
    );

    wfgen_gain_shifter #(.W(W), .GAIN_W(GAIN_W)) shifter_i (
        .raw      (shape_val),
        .gain_sel (gain_sel),
        .scaled   (scaled)
    );

    always_comb begin
        out_d        = out_q;
        out_d.sample = scaled;
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign sample_out = out_q.sample;

    // R1: reset forces the output to zero
    assert_out_reset_R1: assert property (@(posedge clk)
        rst |=> (sample_out == '0));

    // R7: unused shape codes give zero
    assert_blank_codes_R7: assert property (@(posedge clk) disable iff (rst)
        (shape_sel >= 3'd4) |=> (sample_out == '0));

    // R3: unscaled square only takes the two rail values
    assert_square_rails_R3: assert property (@(posedge clk) disable iff (rst)
        ((shape_sel == 3'd0) && (gain_sel == '0)) |=>
            ((sample_out == '0) || (sample_out == MAXV)));

    // R6: unscaled sine code forwards the prior sine input
    assert_sine_forward_R6: assert property (@(posedge clk) disable iff (rst)
        ((shape_sel == 3'd3) && (gain_sel == '0)) |=> (sample_out == $past(sine_in)));

    // R9: the shifted sample never exceeds the shifted full scale
    assert_gain_ceiling_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sample_out <= (MAXV >> $past(gain_sel))));

endmodule

// File: tb/wfgen_core_tb.sv
`timescale 1ns/1ps
module wfgen_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] shape_sel = 3'd0;
    logic [1:0] rate_sel = 2'd0;
    logic [1:0] gain_sel = 2'd0;
    logic [7:0] sine_in = 8'd0;
    logic [7:0] sample_out;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    int         m_phase = 0;
    int         m_pre = 0;
    logic [2:0] m_prev_sel = 3'd0;

    always #10 clk = ~clk;

    wfgen_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .shape_sel  (shape_sel),
        .rate_sel   (rate_sel),
        .gain_sel   (gain_sel),
        .sine_in    (sine_in),
        .sample_out (sample_out)
    );

    // Shape values as the requirements define them (R3..R7)
    function automatic int ref_shape(int ph, logic [2:0] s, logic [7:0] sn);
        case (s)
            3'd0:    return (ph < 128) ? 255 : 0;
            3'd1:    return ph;
            3'd2:    return (ph < 128) ? ph * 2 : 255 - (ph - 128) * 2;
            3'd3:    return int'(sn);
            default: return 0;
        endcase
    endfunction

    // Predictor: pushes the value expected after each rising edge
    always @(posedge clk) begin
        exp_t it;
        int   div;
        if (rst) begin
            m_phase = 0;
            m_pre   = 0;
            it.val  = 8'd0;
            it.tag  = "R1";
        end else begin
            it.val = 8'(ref_shape(m_phase, shape_sel, sine_in) >> gain_sel);
            case (shape_sel)
                3'd0:    it.tag = "R3";
                3'd1:    it.tag = (rate_sel != 2'd0) ? "R8" :
                                  (m_phase == 0) ? "R10" : "R4";
                3'd2:    it.tag = (gain_sel != 2'd0) ? "R9" : "R5";
                3'd3:    it.tag = "R6";
                default: it.tag = "R7";
            endcase
            if (shape_sel != m_prev_sel) it.tag = "R2";
            div = 1 << rate_sel;
            if ((m_pre % div) == div - 1) m_phase = (m_phase + 1) % 256;
            m_pre = (m_pre + 1) % 8;
        end
        m_prev_sel = shape_sel;
        sb_q.push_back(it);
    end

    // Monitor: compares the output away from the active edge
    always @(negedge clk) begin
        exp_t it;
        if (sb_q.size() > 0 && !done) begin
            it = sb_q.pop_front();
            checks++;
            if (sample_out !== it.val) begin
                failures++;
                $display("FAIL %s: sample_out=%0d expected=%0d", it.tag, sample_out, it.val);
            end
        end
    end

    task automatic drive(input logic [2:0] s, input logic [1:0] r,
                         input logic [1:0] g, input int n);
        @(negedge clk);
        shape_sel = s;
        rate_sel  = r;
        gain_sel  = g;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sine_in = sine_in + 8'd37;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(3'd0, 2'd0, 2'd0, 300);   // R3 square
        drive(3'd1, 2'd0, 2'd0, 300);   // R4, R10 ramp and wrap
        drive(3'd2, 2'd0, 2'd0, 300);   // R5 triangle
        drive(3'd3, 2'd0, 2'd0, 300);   // R6 sine forwarding
        for (int g = 1; g < 4; g++) begin
            drive(3'd2, 2'd0, 2'(g), 150);  // R9 gain on triangle
        end
        drive(3'd0, 2'd0, 2'd3, 100);   // R9 gain on square
        drive(3'd3, 2'd0, 2'd2, 100);   // R9 gain on sine
        drive(3'd1, 2'd1, 2'd0, 1100);  // R8 every 2nd clock
        drive(3'd1, 2'd2, 2'd0, 2100);  // R8 every 4th clock
        drive(3'd1, 2'd3, 2'd0, 4200);  // R8 every 8th clock
        drive(3'd2, 2'd3, 2'd1, 300);   // R8/R9 slow scaled triangle
        for (int s = 4; s < 8; s++) begin
            drive(3'(s), 2'd0, 2'd0, 20);   // R7 blank codes
        end
        drive(3'd0, 2'd0, 2'd0, 5);     // R2 switch without phase reset
        drive(3'd2, 2'd0, 2'd0, 5);
        drive(3'd1, 2'd2, 2'd0, 57);
        @(negedge clk);
        rst = 1'b1;                     // R1 reset in mid-run
        repeat (2) @(negedge clk);
        rst = 1'b0;
        drive(3'd1, 2'd1, 2'd0, 600);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule